// File: doc/BRIEF.md
# Scan List Conversion Sequencer

This block drives a multiplexed analog-to-digital front end from a list of scan entries. A host loads 16-bit entries into a write-only queue, picks a settling delay and pulses a start trigger. The block then works through the queue in write order. For each entry it presents the internal channel, the internal gain code, the differential or single-ended select, the expansion-card channel and gain, and the first-entry marker. It holds these outputs through a settling delay, strobes the converter and waits for the converter's done pulse.

After the last entry the block goes back to idle and raises a completion flag. The queue keeps its contents, so the same list can be scanned again. A flush empties the queue before a new list is loaded. Writes past the queue depth are dropped and recorded in a sticky flag. The multiplexer, the amplifiers and the converter are outside this block.

Top module: `scan_sequencer`

## Requirements
- R1: While idle, each `wr_en` pulse appends `wr_data` to the queue. A scan presents the stored entries in the order they were written. Writes made while `busy` is high are ignored.
- R2: A write to a full queue (DEPTH entries, default 16) is dropped and sets `overflow`. `overflow` stays high until a flush is accepted.
- R3: `flush` while idle empties the queue and clears `overflow` and `scan_done`. `flush` while `busy` is high has no effect: the scan completes every entry and `overflow` is kept.
- R4: `start` while idle with a non-empty queue raises `busy` at the next clock edge and clears `scan_done`. `start` with an empty queue leaves `busy` low.
- R5: Field mapping of an entry while it is presented:
  - `ext_chan` = bits 3..0
  - `ext_gain` = bits 5..4
  - `first_mark` = bit 7
  - `int_chan` = bits 11..8
  - `int_gain` = bits 13..12 (codes 0..3 for gains 1, 10, 100, 1000)
  - `diff_sel` = bit 14 (1 = differential)
  - Bit 15 has no effect on any output.
- R6: When bit 14 of the presented entry is 1, `int_chan` bit 3 is driven 0, which limits differential mode to channels 0..7.
- R7: `conv_start` is a single-cycle pulse. It rises exactly 1+N clock edges after the edge that sampled `start` or the previous `conv_done`. N = 10, 20, 40, 40 microseconds × CLK_MHZ for `settle_sel` = 0, 1, 2, 3.
- R8: A `conv_done` sampled after a strobe advances the scan to the next entry. On the last entry, `busy` falls at that same edge and `scan_done` rises to 1.
- R9: After a completed scan the queue is retained, and a new `start` scans the same entries again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Append `wr_data` to the queue |
| wr_data | input | 16 | Scan entry to append |
| flush | input | 1 | Empty the queue (idle only) |
| start | input | 1 | Begin a scan of the queue |
| settle_sel | input | 2 | Settling delay select: 10/20/40/40 µs |
| conv_done | input | 1 | Converter finished the current conversion |
| int_chan | output | 4 | Internal multiplexer channel |
| int_gain | output | 2 | Internal gain code |
| diff_sel | output | 1 | 1 = differential input, 0 = single-ended |
| ext_chan | output | 4 | Expansion-card channel |
| ext_gain | output | 2 | Expansion-card gain code |
| first_mark | output | 1 | First-entry marker of the presented entry |
| conv_start | output | 1 | One-cycle convert strobe |
| busy | output | 1 | Scan in progress |
| scan_done | output | 1 | Last scan completed |
| overflow | output | 1 | Sticky: a write was dropped because the queue was full |

## Verification
The sequencer is run with several lists:
- a single-ended list with mixed gains and one entry with bit 15 set, which separates the field slicing from the unused bit;
- a differential list that includes channel 15, which exposes the channel clamp;
- single-entry lists under each settling code, which tell the delay values apart by exact strobe timing.

An overfilled queue is scanned while a flush is attempted mid-scan. This distinguishes a dropped write from a wrapped one and an ignored flush from an accepted one. A start on an empty queue and a repeated scan of a retained list cover the idle edge cases.

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int DEPTH   = 16,
  parameter int CLK_MHZ = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        flush,
  input  logic        start,
  input  logic [1:0]  settle_sel,
  input  logic        conv_done,
  output logic [3:0]  int_chan,
  output logic [1:0]  int_gain,
  output logic        diff_sel,
  output logic [3:0]  ext_chan,
  output logic [1:0]  ext_gain,
  output logic        first_mark,
  output logic        conv_start,
  output logic        busy,
  output logic        scan_done,
  output logic        overflow
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int N10 = 10 * CLK_MHZ;
  localparam int N20 = 20 * CLK_MHZ;
  localparam int N40 = 40 * CLK_MHZ;
  localparam int SW  = $clog2(N40 + 1);

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_SETTLE, S_CONV, S_WAIT} st_t;

  st_t             st;
  logic [15:0]     mem [DEPTH];
  logic [CW-1:0]   count;
  logic [PW-1:0]   ptr;
  logic [SW-1:0]   wait_cnt;
  logic [SW-1:0]   settle_len;
  logic [15:0]     cur;

  wire idle    = (st == S_IDLE);
  wire full    = (count == CW'(DEPTH));
  wire flush_ok = idle && flush;
  wire last    = ({1'b0, ptr} == CW'(count - CW'(1)));

  always_comb begin
    case (settle_sel)
      2'd0:    settle_len = SW'(N10);
      2'd1:    settle_len = SW'(N20);
      default: settle_len = SW'(N40);
    endcase
  end

  assign cur        = mem[ptr];
  assign ext_chan   = cur[3:0];
  assign ext_gain   = cur[5:4];
  assign first_mark = cur[7];
  assign diff_sel   = cur[14];
  assign int_chan   = {cur[11] & ~cur[14], cur[10:8]};
  assign int_gain   = cur[13:12];
  assign conv_start = (st == S_CONV);
  assign busy       = !idle;

  always_ff @(posedge clk) begin
    if (idle && wr_en && !flush && !full)
      mem[count[PW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      count     <= '0;
      ptr       <= '0;
      wait_cnt  <= '0;
      scan_done <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (flush) begin
            count     <= '0;
            overflow  <= 1'b0;
            scan_done <= 1'b0;
          end else if (wr_en) begin
            if (full) overflow <= 1'b1;
            else      count    <= count + CW'(1);
          end else if (start && count != '0) begin
            st        <= S_SEL;
            ptr       <= '0;
            scan_done <= 1'b0;
          end
        end
        S_SEL: begin
          st       <= S_SETTLE;
          wait_cnt <= settle_len - SW'(1);
        end
        S_SETTLE: begin
          if (wait_cnt == '0) st <= S_CONV;
          else                wait_cnt <= wait_cnt - SW'(1);
        end
        S_CONV: st <= S_WAIT;
        S_WAIT: begin
          if (conv_done) begin
            if (last) begin
              st        <= S_IDLE;
              ptr       <= '0;
              scan_done <= 1'b1;
            end else begin
              st  <= S_SEL;
              ptr <= ptr + PW'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R2
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush_ok) |=> overflow);

  // R6
  diff_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diff_sel |-> !int_chan[3]);

  // R8
  done_vs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !scan_done);

  // R4
  start_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && !flush && !wr_en && count == '0) |=> !busy);

  // R3
  flush_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && flush) |=> $stable(count));
endmodule

// File: tb/sim_scan_sequencer.sv
module sim_scan_sequencer;
  localparam int CLK_MHZ = 10;
  localparam int DEPTH   = 16;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, flush = 0, start = 0, conv_done = 0;
  logic [15:0] wr_data = '0;
  logic [1:0]  settle_sel = '0;
  logic [3:0] int_chan, ext_chan;
  logic [1:0] int_gain, ext_gain;
  logic diff_sel, first_mark, conv_start, busy, scan_done, overflow;

  scan_sequencer #(.DEPTH(DEPTH), .CLK_MHZ(CLK_MHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
    .start(start), .settle_sel(settle_sel), .conv_done(conv_done),
    .int_chan(int_chan), .int_gain(int_gain), .diff_sel(diff_sel),
    .ext_chan(ext_chan), .ext_gain(ext_gain), .first_mark(first_mark),
    .conv_start(conv_start), .busy(busy), .scan_done(scan_done), .overflow(overflow));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int cyc = 0;
  int start_cyc = 0, done_cyc = 0;
  logic [15:0] list [$];
  logic [14:0] exp_q [$];
  int          exp_n [$];
  int          seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] expect_fields(input logic [15:0] w);
    logic [3:0] ic;
    ic = w[14] ? {1'b0, w[10:8]} : w[11:8];
    return {ic, w[13:12], w[14], w[3:0], w[5:4], w[7], 1'b0};
  endfunction

  function automatic int settle_n(input logic [1:0] s);
    case (s)
      2'd0: return 10 * CLK_MHZ;
      2'd1: return 20 * CLK_MHZ;
      default: return 40 * CLK_MHZ;
    endcase
  endfunction

  // monitor and converter model
  int pend = 0;
  always @(negedge clk) begin
    if (conv_done) conv_done <= 0;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        conv_done <= 1;
        done_cyc  <= cyc + 1;
      end
    end
    if (rst_n && conv_start) begin
      logic [14:0] got;
      int trig;
      got = {int_chan, int_gain, diff_sel, ext_chan, ext_gain, first_mark, 1'b0};
      trig = (start_cyc > done_cyc) ? start_cyc : done_cyc;
      seen++;
      if (exp_q.size() == 0) begin
        check(0, "R8", "unexpected strobe", 1, 0);
      end else begin
        logic [14:0] e;
        int n;
        e = exp_q.pop_front();
        n = exp_n.pop_front();
        // R5 R6 R1: fields and ordering
        check(got == e, "R5", "entry fields", int'(got), int'(e));
        // R7: strobe timing
        check(cyc - trig == 1 + n, "R7", "settle edges", cyc - trig, 1 + n);
      end
      pend <= 3;
    end
  end

  task automatic write_word(input logic [15:0] w);
    @(negedge clk);
    wr_en = 1; wr_data = w;
    @(negedge clk);
    wr_en = 0;
    if (list.size() < DEPTH) list.push_back(w);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    list.delete();
  endtask

  task automatic run_scan(input logic [1:0] sel, input bit try_flush);
    settle_sel = sel;
    foreach (list[i]) begin
      exp_q.push_back(expect_fields(list[i]));
      exp_n.push_back(settle_n(sel));
    end
    @(negedge clk);
    start = 1; start_cyc = cyc + 1;
    @(negedge clk);
    start = 0;
    // R4
    check(busy == 1 && scan_done == 0, "R4", "busy after start", busy, 1);
    if (try_flush) begin
      repeat (50) @(negedge clk);
      flush = 1;
      @(negedge clk);
      flush = 0;
    end
    while (busy) @(negedge clk);
    // R8
    check(exp_q.size() == 0, "R8", "entries left", exp_q.size(), 0);
    check(cyc == done_cyc, "R8", "busy fall edge", cyc, done_cyc);
    check(scan_done == 1, "R8", "scan_done", scan_done, 1);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !scan_done && !overflow && !conv_start, "R4", "reset state",
          {busy, scan_done, overflow, conv_start}, 0);

    // R4: start on empty queue is ignored
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(!busy, "R4", "start on empty queue", busy, 0);

    // R1 R5: single-ended list, bit 15 set on one entry
    write_word(16'h0180);
    write_word(16'h2C00);
    write_word(16'hA735);
    run_scan(2'd0, 0);

    // R9: rescan retained list
    run_scan(2'd0, 0);

    // R6: differential list with channel 15
    do_flush();
    check(!scan_done, "R3", "flush clears scan_done", scan_done, 0);
    write_word(16'h4280);
    write_word(16'h4100);
    write_word(16'h4F00);
    write_word(16'h4600);
    run_scan(2'd1, 0);

    // R7: each settle code
    do_flush();
    write_word(16'h1B9A);
    run_scan(2'd2, 0);
    run_scan(2'd3, 0);

    // R2: overflow, and R3: flush during scan ignored
    do_flush();
    for (int k = 0; k < DEPTH + 1; k++)
      write_word({2'b00, 2'(k), 4'(k), (k == 0) ? 1'b1 : 1'b0, 1'b0, 2'(k >> 2), 4'(15 - k)});
    check(overflow, "R2", "overflow after extra write", overflow, 1);
    run_scan(2'd0, 1);
    check(overflow, "R3", "overflow kept after busy flush", overflow, 1);
    check(seen == 3 + 3 + 4 + 1 + 1 + DEPTH, "R2", "total strobes", seen,
          3 + 3 + 4 + 1 + 1 + DEPTH);
    do_flush();
    check(!overflow, "R2", "flush clears overflow", overflow, 0);

    // R3 R4: after flush, queue empty so start ignored
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(!busy, "R3", "queue empty after flush", busy, 0);

    // R1: write while busy ignored
    write_word(16'h0385);
    settle_sel = 0;
    exp_q.push_back(expect_fields(16'h0385));
    exp_n.push_back(settle_n(2'd0));
    @(negedge clk); start = 1; start_cyc = cyc + 1;
    @(negedge clk); start = 0;
    @(negedge clk); wr_en = 1; wr_data = 16'h0999;
    @(negedge clk); wr_en = 0;
    while (busy) @(negedge clk);
    check(exp_q.size() == 0, "R1", "scan of one entry", exp_q.size(), 0);
    exp_q.push_back(expect_fields(16'h0385));
    exp_n.push_back(settle_n(2'd0));
    @(negedge clk); start = 1; start_cyc = cyc + 1;
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
    check(seen == 3 + 3 + 4 + 1 + 1 + DEPTH + 2, "R1", "busy write dropped", seen,
          3 + 3 + 4 + 1 + 1 + DEPTH + 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule